// File: doc/BRIEF.md
# Reciprocal Lookup with Compact Floating-Point Storage

This block returns the reciprocal of a positive fixed-point value. The operand is a 12-bit unsigned number with 3 integer bits and 9 fraction bits, so its range is 0 to just under 8. The operand is used directly as the address into a 4096-word read-only table. Every table word holds 1/X in an 18-bit positive-only floating-point code: a 4-bit exponent above a 14-bit mantissa. The table contents are computed when the design elaborates.

The stored word is expanded back to a 27-bit unsigned fixed-point result, with 10 integer bits and 17 fraction bits. A decoder turns the exponent into a one-hot factor with nine legal positions. A multiplier applies that factor to the mantissa, and a fixed left shift of 5 places the product. The result is registered and is presented one clock after an accepted operand. A typical use is a normalising divider, where a numerator is multiplied by the reciprocal of a sum that would otherwise need a true division.

Top module: `recip_sfp_lut`

## Requirements
- R1: While `rst` is high, at the next rising edge `recip` becomes 0 and `out_valid` becomes 0.
- R2: When `in_valid` is high at a rising edge, `out_valid` is high after that edge and `recip` shows the result for the `x_in` sampled at that edge. When `in_valid` is low at a rising edge, `out_valid` is low after it.
- R3: For an address a from 1 to 4095, the word stores the smallest exponent e in 0..8 for which m = floor((2^(21-e) + floor(a/2)) / a) is below 16384. The mantissa is that m, and `recip` equals m * 2^(e+5).
- R4: Address 0 stores exponent 8 with an all-ones mantissa, so `recip` saturates to 0x7FFE000.
- R5: Address 1 (X = 1/512) yields exactly 2^26 (0x4000000, which is 512.0).
- R6: For addresses 1 to 512, where the reciprocal is at least 1.0, the relative error of `recip` against 2^26/a is at most 0.013 percent.
- R7: While `in_valid` is low, `recip` holds its last value whatever `x_in` does.
- R8: Address 4095 yields 16384 (exponent 0, mantissa 512), and no accepted address ever yields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand on `x_in` is accepted at this edge |
| x_in | input | 12 | Operand, unsigned, 3 integer and 9 fraction bits |
| out_valid | output | 1 | `recip` holds a fresh result |
| recip | output | 27 | Reciprocal, unsigned, 10 integer and 17 fraction bits |

## Verification
Every result is due exactly one rising edge after the edge that accepts its operand, and `out_valid` follows `in_valid` with that same single-edge delay. The bench changes inputs on falling edges. It reads each result at the next falling edge, which is half a period after the edge that registered it. In streams, each read checks the operand driven one falling edge earlier. The hold checks read the outputs over three further falling edges after `in_valid` drops while `x_in` keeps moving.

// File: rtl/recip_sfp_lut.sv
module recip_sfp_lut #(
  parameter int XW   = 12,
  parameter int XF   = 9,
  parameter int MW   = 14,
  parameter int EW   = 4,
  parameter int EMAX = 8,
  parameter int OW   = 27
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [XW-1:0] x_in,
  output logic          out_valid,
  output logic [OW-1:0] recip
);

  localparam int DEPTH = 1 << XW;
  localparam int WW    = EW + MW;
  localparam int OF    = OW - 1 - XF;
  localparam int BIAS  = OW - 1 - EMAX - (MW - 1);
  localparam int NUMSH = XF + OF - BIAS;

  function automatic logic [WW-1:0] pack_inv(input int unsigned a);
    longint unsigned m;
    if (a == 0) return {EW'(EMAX), {MW{1'b1}}};
    for (int e = 0; e <= EMAX; e++) begin
      m = ((64'd1 << (NUMSH - e)) + 64'(a / 2)) / 64'(a);
      if (m < (64'd1 << MW)) return {EW'(e), MW'(m)};
    end
    return {EW'(EMAX), {MW{1'b1}}};
  endfunction

  logic [WW-1:0] table_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign table_w[g] = pack_inv(g);
  end

  wire [WW-1:0] word = table_w[x_in];
  wire [EW-1:0] ex   = word[WW-1:MW];
  wire [MW-1:0] mant = word[MW-1:0];

  logic [EMAX:0] hot;
  always_comb begin
    hot = '0;
    for (int k = 0; k <= EMAX; k++)
      if (ex == EW'(k)) hot[k] = 1'b1;
  end

  wire [OW-1:0] fixed = (OW'(mant) * OW'(hot)) << BIAS;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      recip     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) recip <= fixed;
    end
  end

endmodule

// File: rtl/recip_sfp_lut_chk.sv
module recip_sfp_lut_chk #(
  parameter int XW   = 12,
  parameter int XF   = 9,
  parameter int MW   = 14,
  parameter int EMAX = 8,
  parameter int OW   = 27
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [XW-1:0] x_in,
  input logic          out_valid,
  input logic [OW-1:0] recip
);

  localparam int BIAS = OW - 1 - EMAX - (MW - 1);
  localparam logic [OW-1:0] SAT = OW'(((64'd1 << MW) - 1) << (EMAX + BIAS));
  localparam logic [OW-1:0] ONE = OW'(64'd1 << (OW - 1));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r2_idle_drops: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(recip));

  a_r4_zero_sat: assert property (@(posedge clk) disable iff (rst)
    (in_valid && x_in == '0) |=> recip == SAT);

  a_r5_unit: assert property (@(posedge clk) disable iff (rst)
    (in_valid && x_in == XW'(1)) |=> recip == ONE);

  a_r8_nonzero: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> recip != '0);

endmodule

bind recip_sfp_lut recip_sfp_lut_chk #(
  .XW(XW), .XF(XF), .MW(MW), .EMAX(EMAX), .OW(OW)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .x_in(x_in),
  .out_valid(out_valid), .recip(recip)
);

// File: tb/tb_recip_sfp_lut.sv
`timescale 1ns/1ps
module tb_recip_sfp_lut;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [11:0] x_in = '0;
  logic        out_valid;
  logic [26:0] recip;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit pend = 0;
  logic [11:0] pa = '0;

  always #2.5 clk = ~clk;

  recip_sfp_lut dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .x_in(x_in),
    .out_valid(out_valid), .recip(recip)
  );

  function automatic longint unsigned ref_recip(input int unsigned a);
    longint unsigned m;
    if (a == 0) return 64'h7FFE000;
    for (int e = 0; e <= 8; e++) begin
      m = ((64'd1 << (21 - e)) + 64'(a / 2)) / 64'(a);
      if (m < 16384) return m << (e + 5);
    end
    return 64'h7FFE000;
  endfunction

  task automatic expect_eq(input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_res(input logic [11:0] a);
    real ideal, err;
    expect_eq("R2 out_valid", 64'(out_valid), 64'd1);
    if (a == 0)         expect_eq("R4 saturation", 64'(recip), 64'h7FFE000);
    else if (a == 1)    expect_eq("R5 unit", 64'(recip), 64'h4000000);
    else if (a == 4095) expect_eq("R8 smallest", 64'(recip), 64'd16384);
    else                expect_eq("R3 encoding", 64'(recip), ref_recip(a));
    if (a != 0) begin
      checks++;
      if (recip == 0) begin
        errors++;
        $display("FAIL R8 nonzero: actual 0x0 expected nonzero at addr %0d", a);
      end
    end
    if (a >= 1 && a <= 512) begin
      ideal = 67108864.0 / real'(a);
      err = (real'(recip) - ideal) / ideal;
      if (err < 0.0) err = -err;
      checks++;
      if (err > 1.3e-4) begin
        errors++;
        $display("FAIL R6 accuracy: actual %0d expected %f (addr %0d)", recip, ideal, a);
      end
    end
  endtask

  task automatic drive(input logic [11:0] a);
    @(negedge clk);
    if (pend) check_res(pa);
    x_in = a;
    in_valid = 1'b1;
    pend = 1;
    pa = a;
  endtask

  task automatic flush_hold();
    logic [26:0] last;
    @(negedge clk);
    if (pend) check_res(pa);
    pend = 0;
    in_valid = 1'b0;
    last = recip;
    for (int k = 0; k < 3; k++) begin
      x_in = 12'(k * 1000 + 77);
      @(negedge clk);
      expect_eq("R7 hold value", 64'(recip), 64'(last));
      expect_eq("R2 out_valid low", 64'(out_valid), 64'd0);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    expect_eq("R1 reset recip", 64'(recip), 64'd0);
    expect_eq("R1 reset out_valid", 64'(out_valid), 64'd0);
    rst = 1'b0;

    drive(12'd0);
    drive(12'd1);
    drive(12'd2);
    drive(12'd4095);
    drive(12'd512);
    drive(12'd511);
    drive(12'd3);
    drive(12'd4094);
    drive(12'd256);
    flush_hold();

    for (int i = 0; i < 3000; i++) begin
      drive(12'($urandom_range(0, 4095)));
      if ($urandom_range(0, 99) == 0) flush_hold();
    end
    for (int i = 1; i <= 512; i += 7) drive(12'(i));
    flush_hold();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule